// File: doc/BRIEF.md
# I/O Request Address Range Router

This block decides where a memory request issued by an I/O device should go. It holds a small table of address windows. When a request from an I/O device lands inside a window that is switched on, the block reports that the request must be bounced back to the I/O bus and not served from system memory. Any other request goes to memory. Requests from the processor are never matched against the table, because a separate processor-side mapping handles them.

Software fills the table through an indirect register path. It first writes a select word that names a bus, a device, a function and a register offset. It then reads or writes the chosen register through a data port. Each table entry has a sticky lock. Once the lock is set, that entry cannot be changed again until reset, and this includes clearing the lock itself.

Lookups take one clock from request to response. The result is a routing flag plus the number of the matching entry. Window addresses are kept at 64 KiB granularity.

Top module: `amap_dma_route`

## Requirements
- R1: A reset clears every window start, window end, enable and lock bit. After reset every table register reads zero and every lookup misses.
- R2: The select word carries the register offset in bits [7:2], the function in [10:8], the device in [15:11] and the bus in [23:16]. Bits [31:24] and [1:0] are ignored. The block answers on bus 0, device 24, function 1. Entry i has its start register at dword offset 0x10+2i and its end register at 0x11+2i. A write through the data port stores into the selected register and a later read returns it.
- R3: When the select word names any other bus, device or function, a data write changes nothing and a data read returns 0xFFFFFFFF. A read of an offset inside the function that is outside the table returns zero.
- R4: The start register holds the window start page (address bits [39:16]) in bits [31:8], the lock in bit 1 and the enable in bit 0. The end register holds the window end page in bits [31:8]. An I/O request hits an entry when start ≤ address[39:16] ≤ end. The end bound is inclusive, so every byte of the last 64 KiB page matches.
- R5: An entry whose enable bit is clear never matches. An entry whose start is above its end matches nothing.
- R6: A request flagged as coming from the processor always gets a memory route (no hit), whatever the table holds.
- R7: When several enabled entries match an I/O request, the response gives the lowest-numbered one. On a miss the index is 0.
- R8: Once an entry's lock bit is set, writes to its start and end registers are ignored until reset. This includes an attempt to clear the lock. Other entries stay writable.
- R9: The response valid, routing flag and index appear one clock after the request is sampled. Read data appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel_we | input | 1 | Load the select word |
| cfg_sel_wdata | input | 32 | Select word (bus, device, function, offset) |
| cfg_data_we | input | 1 | Write the selected register |
| cfg_data_re | input | 1 | Read the selected register |
| cfg_data_wdata | input | 32 | Data for a register write |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request present |
| req_from_io | input | 1 | 1 = request issued by an I/O device, 0 = by the processor |
| req_addr | input | 40 | Physical request address |
| rsp_valid | output | 1 | Response present |
| rsp_to_io | output | 1 | 1 = send the request back to I/O space, 0 = system memory |
| rsp_idx | output | 3 | Number of the winning entry |

## Verification
The assertions assume that the select word and the data strobes are never driven in the same cycle. They also assume that a data access always uses a select word that was loaded at least one clock earlier, and that the request inputs are stable around the sampling edge. The bench meets these assumptions by driving every input on the falling edge and by giving each select load, data access and request a cycle of its own. The expected routes come from a mirror of the table that the bench keeps from the register rules alone. That mirror skips locked and foreign writes. The bench sweeps both ends of each 64 KiB page across overlapping, disabled, inverted, single-page and top-of-space windows.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int unsigned CFG_W = 32;
  localparam logic [5:0] MAP_DW0 = 6'h10;

  typedef struct packed {
    logic [7:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
    logic [1:0] bo;
  } cfg_sel_t;
endpackage

// File: rtl/amap_cfg_decode.sv
module amap_cfg_decode
  import amap_pkg::*;
#(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter logic [7:0]  MY_BUS = 8'd0,
  parameter logic [4:0]  MY_DEV = 5'd24,
  parameter logic [2:0]  MY_FN  = 3'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_we,
  input  logic [CFG_W-1:0]   sel_wdata,
  output logic               fn_hit,
  output logic               reg_in_map,
  output logic [IDX_W-1:0]   reg_ent,
  output logic               reg_is_lim
);
  cfg_sel_t   sel_q;
  logic [6:0] rel;
  logic       sel_unused;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (sel_we) sel_q <= cfg_sel_t'(sel_wdata);
  end

  assign sel_unused = ^{sel_q.rsvd, sel_q.bo};
  assign fn_hit     = (sel_q.bus == MY_BUS) && (sel_q.dev == MY_DEV) && (sel_q.fn == MY_FN);
  assign rel        = {1'b0, sel_q.dw} - {1'b0, MAP_DW0};
  assign reg_in_map = !rel[6] && (rel < 7'(2 * N_ENT));
  assign reg_ent    = rel[IDX_W:1];
  assign reg_is_lim = rel[0];

  a_r2_sel_load: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> (sel_q == cfg_sel_t'($past(sel_wdata))));
endmodule

// File: rtl/amap_entry_bank.sv
module amap_entry_bank
  import amap_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned PG_W  = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_ent,
  input  logic                       wr_lim,
  input  logic [CFG_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]           rd_ent,
  input  logic                       rd_lim,
  output logic [CFG_W-1:0]           rd_word,
  output logic [N_ENT-1:0][PG_W-1:0] base_pg,
  output logic [N_ENT-1:0][PG_W-1:0] lim_pg,
  output logic [N_ENT-1:0]           re_vec
);
  logic [N_ENT-1:0] lock_q;
  logic             wr_unused;

  assign wr_unused = ^wr_data[CFG_W-1-PG_W:2];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic sel_here;
    assign sel_here = wr_en && (wr_ent == IDX_W'(i)) && !lock_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        base_pg[i] <= '0;
        lim_pg[i]  <= '0;
        re_vec[i]  <= 1'b0;
        lock_q[i]  <= 1'b0;
      end else if (sel_here) begin
        if (wr_lim) begin
          lim_pg[i] <= wr_data[CFG_W-1 -: PG_W];
        end else begin
          base_pg[i] <= wr_data[CFG_W-1 -: PG_W];
          lock_q[i]  <= wr_data[1];
          re_vec[i]  <= wr_data[0];
        end
      end
    end

    // R8: a locked entry keeps its lock and every field until reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> lock_q[i]);
    a_r8_locked_frozen: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> ($stable(base_pg[i]) && $stable(lim_pg[i]) && $stable(re_vec[i])));
  end

  always_comb begin
    rd_word = '0;
    if (rd_lim) begin
      rd_word[CFG_W-1 -: PG_W] = lim_pg[rd_ent];
    end else begin
      rd_word[CFG_W-1 -: PG_W] = base_pg[rd_ent];
      rd_word[1] = lock_q[rd_ent];
      rd_word[0] = re_vec[rd_ent];
    end
  end
endmodule

// File: rtl/amap_lookup.sv
module amap_lookup #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned PG_W  = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_io,
  input  logic [PG_W-1:0]            req_pg,
  input  logic [N_ENT-1:0][PG_W-1:0] base_pg,
  input  logic [N_ENT-1:0][PG_W-1:0] lim_pg,
  input  logic [N_ENT-1:0]           re_vec,
  output logic                       rsp_valid,
  output logic                       rsp_to_io,
  output logic [IDX_W-1:0]           rsp_idx
);
  logic [N_ENT-1:0] match;
  logic [IDX_W-1:0] pick;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign match[i] = re_vec[i] && req_io &&
                      (base_pg[i] <= req_pg) && (req_pg <= lim_pg[i]);
  end

  always_comb begin
    pick = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) pick = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_to_io <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_to_io <= req_valid && (|match);
      rsp_idx   <= pick;
    end
  end

  a_r6_cpu_to_mem: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_io) |=> (rsp_valid && !rsp_to_io));
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_to_io));
  a_r5_hit_enabled: assert property (@(posedge clk) disable iff (rst)
    rsp_to_io |-> (|($past(re_vec) & (N_ENT'(1) << rsp_idx))));
endmodule

// File: rtl/amap_dma_route.sv
module amap_dma_route
  import amap_pkg::*;
#(
  parameter int unsigned N_ENT    = 8,
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned PAGE_LSB = 16,
  parameter logic [7:0]  MY_BUS   = 8'd0,
  parameter logic [4:0]  MY_DEV   = 5'd24,
  parameter logic [2:0]  MY_FN    = 3'd1,
  localparam int unsigned IDX_W   = $clog2(N_ENT),
  localparam int unsigned PG_W    = ADDR_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sel_we,
  input  logic [31:0]       cfg_sel_wdata,
  input  logic              cfg_data_we,
  input  logic              cfg_data_re,
  input  logic [31:0]       cfg_data_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_from_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_to_io,
  output logic [IDX_W-1:0]  rsp_idx
);
  logic                       fn_hit, reg_in_map, reg_is_lim;
  logic [IDX_W-1:0]           reg_ent;
  logic [CFG_W-1:0]           rd_word;
  logic [N_ENT-1:0][PG_W-1:0] base_pg, lim_pg;
  logic [N_ENT-1:0]           re_vec;
  logic                       addr_unused;

  assign addr_unused = ^req_addr[PAGE_LSB-1:0];

  amap_cfg_decode #(
    .N_ENT(N_ENT), .IDX_W(IDX_W), .MY_BUS(MY_BUS), .MY_DEV(MY_DEV), .MY_FN(MY_FN)
  ) dec_i (
    .clk(clk), .rst(rst), .sel_we(cfg_sel_we), .sel_wdata(cfg_sel_wdata),
    .fn_hit(fn_hit), .reg_in_map(reg_in_map), .reg_ent(reg_ent), .reg_is_lim(reg_is_lim)
  );

  amap_entry_bank #(.N_ENT(N_ENT), .IDX_W(IDX_W), .PG_W(PG_W)) bank_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_data_we && fn_hit && reg_in_map),
    .wr_ent(reg_ent), .wr_lim(reg_is_lim), .wr_data(cfg_data_wdata),
    .rd_ent(reg_ent), .rd_lim(reg_is_lim), .rd_word(rd_word),
    .base_pg(base_pg), .lim_pg(lim_pg), .re_vec(re_vec)
  );

  amap_lookup #(.N_ENT(N_ENT), .IDX_W(IDX_W), .PG_W(PG_W)) look_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_io(req_from_io),
    .req_pg(req_addr[ADDR_W-1:PAGE_LSB]),
    .base_pg(base_pg), .lim_pg(lim_pg), .re_vec(re_vec),
    .rsp_valid(rsp_valid), .rsp_to_io(rsp_to_io), .rsp_idx(rsp_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_data_re) begin
      if (!fn_hit) cfg_rdata <= '1;
      else if (reg_in_map) cfg_rdata <= rd_word;
      else cfg_rdata <= '0;
    end
  end

  a_r3_foreign_ones: assert property (@(posedge clk) disable iff (rst)
    (cfg_data_re && !fn_hit) |=> (cfg_rdata == '1));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_data_re |=> $stable(cfg_rdata));
endmodule

// File: tb/amap_dma_route_tb_top.sv
module amap_dma_route_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_sel_we = 1'b0, cfg_data_we = 1'b0, cfg_data_re = 1'b0;
  logic [31:0] cfg_sel_wdata = '0, cfg_data_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_from_io = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_to_io;
  logic [2:0]  rsp_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [23:0] m_base [8];
  logic [23:0] m_lim  [8];
  logic        m_re   [8];
  logic        m_lock [8];

  always #5 clk = ~clk;

  amap_dma_route dut_i (
    .clk(clk), .rst(rst), .cfg_sel_we(cfg_sel_we), .cfg_sel_wdata(cfg_sel_wdata),
    .cfg_data_we(cfg_data_we), .cfg_data_re(cfg_data_re), .cfg_data_wdata(cfg_data_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_from_io(req_from_io),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_to_io(rsp_to_io), .rsp_idx(rsp_idx)
  );

  function automatic logic [31:0] sel(input logic [7:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] dw);
    return {8'hA5, b, d, f, dw, 2'b11};
  endfunction

  function automatic logic [5:0] ent_dw(input int e, input bit lim);
    return 6'h10 + 6'(2 * e + int'(lim));
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_re[i] = 1'b0; m_lock[i] = 1'b0;
    end
  endtask

  task automatic load_sel(input logic [31:0] w);
    @(negedge clk); cfg_sel_we = 1'b1; cfg_sel_wdata = w;
    @(negedge clk); cfg_sel_we = 1'b0;
  endtask

  task automatic data_wr(input logic [31:0] d);
    @(negedge clk); cfg_data_we = 1'b1; cfg_data_wdata = d;
    @(negedge clk); cfg_data_we = 1'b0;
  endtask

  task automatic data_rd(output logic [31:0] d);
    @(negedge clk); cfg_data_re = 1'b1;
    @(negedge clk); cfg_data_re = 1'b0; d = cfg_rdata;
  endtask

  task automatic set_base(input int e, input logic [23:0] pg, input bit lk, input bit en);
    load_sel(sel(8'd0, 5'd24, 3'd1, ent_dw(e, 1'b0)));
    data_wr({pg, 6'b0, lk, en});
    if (!m_lock[e]) begin m_base[e] = pg; m_lock[e] = lk; m_re[e] = en; end
  endtask

  task automatic set_lim(input int e, input logic [23:0] pg);
    load_sel(sel(8'd0, 5'd24, 3'd1, ent_dw(e, 1'b1)));
    data_wr({pg, 8'hFC});
    if (!m_lock[e]) m_lim[e] = pg;
  endtask

  task automatic verify_regs(input string tag);
    logic [31:0] d;
    for (int e = 0; e < 8; e++) begin
      load_sel(sel(8'd0, 5'd24, 3'd1, ent_dw(e, 1'b0)));
      data_rd(d);
      check($sformatf("%s start e%0d", tag, e), 40'(d), 40'({m_base[e], 6'b0, m_lock[e], m_re[e]}));
      load_sel(sel(8'd0, 5'd24, 3'd1, ent_dw(e, 1'b1)));
      data_rd(d);
      check($sformatf("%s end e%0d", tag, e), 40'(d), 40'({m_lim[e], 8'h00}));
    end
  endtask

  task automatic lookup(input logic [39:0] a, input logic io, input string tag);
    logic       hit;
    logic [2:0] idx;
    hit = 1'b0; idx = '0;
    if (io) begin
      for (int i = 7; i >= 0; i--) begin
        if (m_re[i] && m_base[i] <= a[39:16] && a[39:16] <= m_lim[i]) begin
          hit = 1'b1; idx = 3'(i);
        end
      end
    end
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_from_io = io;
    @(negedge clk); req_valid = 1'b0;
    check({tag, " R9 valid"}, 40'(rsp_valid), 40'd1);
    check($sformatf("%s route a=%h", tag, a), 40'(rsp_to_io), 40'(hit));
    check($sformatf("%s index a=%h", tag, a), 40'(rsp_idx), 40'(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R9 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1: reset state
    check("R1 rdata after reset", 40'(cfg_rdata), 40'd0);
    check("R1 rsp_valid after reset", 40'(rsp_valid), 40'd0);
    verify_regs("R1");
    lookup(40'h00_0002_0000, 1'b1, "R1 empty table");

    // R3: foreign function accesses
    load_sel(sel(8'd1, 5'd24, 3'd1, ent_dw(0, 1'b0))); data_rd(d);
    check("R3 read wrong bus", 40'(d), 40'hFFFF_FFFF);
    data_wr(32'hFFFF_FFFF);
    load_sel(sel(8'd0, 5'd25, 3'd1, ent_dw(0, 1'b1))); data_rd(d);
    check("R3 read wrong device", 40'(d), 40'hFFFF_FFFF);
    data_wr(32'hFFFF_FFFF);
    load_sel(sel(8'd0, 5'd24, 3'd2, ent_dw(1, 1'b0))); data_rd(d);
    check("R3 read wrong function", 40'(d), 40'hFFFF_FFFF);
    data_wr(32'hFFFF_FFFF);
    load_sel(sel(8'd0, 5'd24, 3'd1, 6'h00)); data_rd(d);
    check("R3 read unused offset", 40'(d), 40'd0);
    data_wr(32'hFFFF_FFFF);
    verify_regs("R3 after foreign writes");

    // R2/R4/R5/R7: program overlapping, disabled, inverted windows
    set_base(0, 24'd2, 1'b0, 1'b1);  set_lim(0, 24'd5);
    set_base(1, 24'd4, 1'b0, 1'b1);  set_lim(1, 24'd9);
    set_base(2, 24'd12, 1'b0, 1'b0); set_lim(2, 24'd12);
    set_base(3, 24'd20, 1'b0, 1'b1); set_lim(3, 24'd16);
    set_base(4, 24'd24, 1'b0, 1'b1); set_lim(4, 24'd24);
    set_base(5, 24'd30, 1'b0, 1'b1); set_lim(5, 24'd40);
    set_base(6, 24'hFFFFF0, 1'b0, 1'b1); set_lim(6, 24'hFFFFFF);
    set_base(7, 24'd33, 1'b0, 1'b1); set_lim(7, 24'd50);
    verify_regs("R2 readback");

    for (int p = 0; p < 64; p++) begin
      lookup({24'(p), 16'h0000}, 1'b1, "R4 R5 R7 low edge");
      lookup({24'(p), 16'hFFFF}, 1'b1, "R4 R5 R7 high edge");
    end
    lookup(40'hFF_FFEF_FFFF, 1'b1, "R4 below top window");
    lookup(40'hFF_FFF0_0000, 1'b1, "R4 top window start");
    lookup(40'hFF_FFFF_FFFF, 1'b1, "R4 top of space");

    // R6: processor requests bypass the table
    lookup(40'h00_0002_1234, 1'b0, "R6 cpu");
    lookup(40'h00_0018_0000, 1'b0, "R6 cpu");
    lookup(40'hFF_FFFF_FFFF, 1'b0, "R6 cpu");

    // R8: lock entry 5, then attempt to change it
    set_base(5, 24'd30, 1'b1, 1'b1);
    set_base(5, 24'd0, 1'b0, 1'b0);
    set_lim(5, 24'd0);
    set_base(4, 24'd24, 1'b0, 1'b1); set_lim(4, 24'd26);
    verify_regs("R8 after lock");
    lookup({24'd35, 16'h8000}, 1'b1, "R8 locked still routes");
    lookup({24'd26, 16'hFFFF}, 1'b1, "R8 unlocked entry rewritten");

    // R1/R8: reset releases the lock and clears the table
    do_reset();
    verify_regs("R1 R8 after second reset");
    lookup({24'd35, 16'h0000}, 1'b1, "R1 miss after reset");
    set_base(5, 24'd1, 1'b0, 1'b1); set_lim(5, 24'd1);
    verify_regs("R8 writable after reset");
    lookup({24'd1, 16'h0001}, 1'b1, "R8 relocked entry usable");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule